// File: doc/BRIEF.md
# Paired-Pointer I2C Target

This block is the serial front end of a small eight-register port expander. It watches a two-wire bus through an oversampled system clock, recognises its own 7-bit address (a fixed upper part plus a strap value from pins), and then moves bytes between the bus and an external register bank. The bank is reached through a pointer, a write strobe with its data, and a combinational read-data input.

The first byte after a matching write address is a command byte. Its low three bits load the register pointer. Each data byte that follows is written at the pointed register. A read is a write of the command byte, then a repeated START and the address with the read bit set. After every data byte, written or read, the pointer flips only its lowest bit. Transfers therefore bounce between the two registers of a pair (0/1, 2/3, 4/5, 6/7) for as many bytes as the master sends or asks for. The pointer is kept between transactions, so a later read with no command byte resumes where the last access stopped.

The bench drives SDA as an open-drain line: the line is the AND of the master's level and the inverse of `sda_oe_o`.

Top module: `i2c_pair_target`

## Requirements
- R1: The block acknowledges an address byte (it pulls SDA low through the 9th SCL high phase) only when the 7 address bits equal binary 0100 followed by `strap_i[2:1:0]` in that order, MSB first. Bit 0 of the address byte is R/W, with 1 meaning read. SDA is only pulled low while SCL is low.
- R2: After an address mismatch, the block drives no SDA, writes no register and leaves the pointer unchanged until the next START.
- R3: Bits [2:0] of the command byte load the pointer, and bits [7:3] are ignored. The command byte is acknowledged.
- R4: Each write data byte is acknowledged. During the high phase of its acknowledge clock, the byte is presented on `reg_wdata_o` with a one-cycle `reg_wr_o` pulse, addressed by the pointer value before it flips.
- R5: After each written byte, pointer bit 0 inverts and bits [2:1] are kept. Any number of bytes may follow in one transaction.
- R6: After an address byte with R/W=1, the block returns the pointed register MSB first, then flips pointer bit 0 after each byte read, whether the master acknowledges it or not.
- R7: The pointer keeps its value across STOP and START, so a read with no command byte starts at the register the last access left.
- R8: After the master does not acknowledge a read byte, the block releases SDA and keeps it released until the next START.
- R9: A STOP at any point ends the transfer. A partly received byte is discarded, and bytes already acknowledged stay written.
- R10: An SDA fall while SCL is high is a START (including a repeated START mid-transaction), and it returns the block to address reception. An SDA rise while SCL is high is a STOP.
- R11: After reset the pointer is 0, SDA is released and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 3 | Low address bits from strap pins |
| reg_ptr_o | output | 3 | Register pointer to the bank |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data for the pointed register |
| reg_rdata_i | input | 8 | Contents of the pointed register |

## Verification
The assertions assume that SCL and SDA each stay at a level for well over the synchroniser depth plus two clock cycles. This ensures every bus edge appears as a single detected event, and the one-cycle strobes land inside the phase they belong to. They also assume that the master leaves SDA high whenever the target owns it. The bench therefore spaces every bus transition ten system clocks apart. It changes SDA only while SCL is low, except when it deliberately forms START and STOP. It releases SDA during every acknowledge or read bit that the target drives.

// File: rtl/i2c_pair_pkg.sv
package i2c_pair_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_pair_line_sync.sv
module i2c_pair_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_q     <= scl_chain[STAGES-1];
      sda_q     <= sda_chain[STAGES-1];
    end
  end

  assign scl_o      = scl_chain[STAGES-1];
  assign sda_o      = sda_chain[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edges only count as conditions while SCL stayed high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_pair_ptr.sv
module i2c_pair_ptr #(
  parameter int unsigned PTR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             flip_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (flip_i) ptr_q <= {ptr_q[PTR_W-1:1], ~ptr_q[0]};
  end

  assign ptr_o = ptr_q;

  // R5
  pair_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_i && !load_i) |=> (ptr_q[PTR_W-1:1] == $past(ptr_q[PTR_W-1:1]))
                            && (ptr_q[0] != $past(ptr_q[0])));
  // R7
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flip_i && !load_i) |=> $stable(ptr_q));
endmodule

// File: rtl/i2c_pair_target.sv
module i2c_pair_target
  import i2c_pair_pkg::*;
#(
  parameter int unsigned STRAP_W     = 3,
  parameter logic [6:0]  BASE_ADDR   = 7'b0100000,
  parameter int unsigned PTR_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [PTR_W-1:0]   reg_ptr_o,
  output logic               reg_wr_o,
  output logic [BYTE_W-1:0]  reg_wdata_o,
  input  logic [BYTE_W-1:0]  reg_rdata_i
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;

  i2c_pair_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  tgt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full_q, rw_q, mack_q;
  logic [BYTE_W-1:0] sr_q;
  logic              sda_oe_q, wr_en_q, ptr_load_q, rd_flip_q;
  logic [6:0]        addr_rx;
  logic              addr_hit;

  assign addr_rx  = sr_q[BYTE_W-1:1];
  assign addr_hit = (addr_rx[6:STRAP_W] == BASE_ADDR[6:STRAP_W])
                 && (addr_rx[STRAP_W-1:0] == strap_i);

  i2c_pair_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i, .rst_ni,
    .load_i(ptr_load_q),
    .load_val_i(sr_q[PTR_W-1:0]),
    .flip_i(wr_en_q | rd_flip_q),
    .ptr_o(reg_ptr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      full_q     <= 1'b0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      sr_q       <= '0;
      sda_oe_q   <= 1'b0;
      wr_en_q    <= 1'b0;
      ptr_load_q <= 1'b0;
      rd_flip_q  <= 1'b0;
    end else begin
      wr_en_q    <= 1'b0;
      ptr_load_q <= 1'b0;
      rd_flip_q  <= 1'b0;
      if (start) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        full_q   <= 1'b0;
        sda_oe_q <= 1'b0;
      end else if (stop) begin
        state_q  <= ST_IDLE;
        full_q   <= 1'b0;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise && !full_q) begin
              sr_q  <= {sr_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CNT_LAST) full_q <= 1'b1;
            end else if (scl_fall && full_q) begin
              full_q <= 1'b0;
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  rw_q     <= sr_q[0];
                  sda_oe_q <= 1'b1;
                  state_q  <= ST_ADDR_ACK;
                end else begin
                  state_q  <= ST_IGNORE;
                end
              end else if (state_q == ST_CMD) begin
                ptr_load_q <= 1'b1;
                sda_oe_q   <= 1'b1;
                state_q    <= ST_CMD_ACK;
              end else begin
                sda_oe_q <= 1'b1;
                state_q  <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              sr_q     <= reg_rdata_i;
              sda_oe_q <= ~reg_rdata_i[BYTE_W-1];
              state_q  <= ST_RDATA;
            end else begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_CMD;
            end
          end
          ST_CMD_ACK: if (scl_fall) begin
            sda_oe_q <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_WDATA;
          end
          ST_WDATA_ACK: begin
            if (scl_rise) wr_en_q <= 1'b1;  // commit on the ack clock
            else if (scl_fall) begin
              sda_oe_q <= 1'b0;
              cnt_q    <= '0;
              state_q  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CNT_LAST) full_q <= 1'b1;
            end else if (scl_fall) begin
              if (full_q) begin
                full_q   <= 1'b0;
                sda_oe_q <= 1'b0;
                state_q  <= ST_RACK;
              end else begin
                sr_q     <= {sr_q[BYTE_W-2:0], 1'b0};
                sda_oe_q <= ~sr_q[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              rd_flip_q <= 1'b1;
              mack_q    <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                sr_q     <= reg_rdata_i;
                sda_oe_q <= ~reg_rdata_i[BYTE_W-1];
                state_q  <= ST_RDATA;
              end else begin
                state_q  <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = sda_oe_q;
  assign reg_wr_o    = wr_en_q;
  assign reg_wdata_o = sr_q;

  // R10
  start_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (state_q == ST_ADDR) && !sda_oe_q);
  // R9
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (state_q == ST_IDLE) && !sda_oe_q);
  // R4
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |=> !wr_en_q);
  // R4
  wr_ack_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_q) |-> scl_s);
  // R1
  drive_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !scl_s);
  // R2
  ignore_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> !sda_oe_q && !wr_en_q && !ptr_load_q);
endmodule

// File: tb/i2c_pair_target_tb.sv
module i2c_pair_target_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b000;
  logic       sda_oe, reg_wr;
  logic [2:0] reg_ptr;
  logic [7:0] reg_wdata, reg_rdata;
  wire        sda_line = sda_m & ~sda_oe;

  i2c_pair_target u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .reg_ptr_o(reg_ptr),
    .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  logic [7:0] bank [8];
  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 8; i++) bank[i] <= 8'(8'h11 * (i + 1));
    else if (reg_wr) bank[reg_ptr] <= reg_wdata;
  end
  assign reg_rdata = bank[reg_ptr];

  logic [7:0] exp_bank [8];
  logic [2:0] eptr;
  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); d[i] = sda_line; tick(Q); scl_m = 1'b0;
    end
    sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
    tick(Q); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
    return {4'b0100, s, rd};
  endfunction

  task automatic check_bank(input string req);
    for (int i = 0; i < 8; i++) chk(req, bank[i], exp_bank[i]);
  endtask

  task automatic do_write(input logic [7:0] cmd, input int n, input logic [7:0] d [5]);
    logic a;
    i2c_start();
    send_byte(addr_byte(strap, 1'b0), a); chk("R1 address ack", a, 1'b1);
    send_byte(cmd, a);                    chk("R3 command ack", a, 1'b1);
    eptr = cmd[2:0];
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], a); chk("R4 data ack", a, 1'b1);
      exp_bank[eptr] = d[k];
      eptr[0] = ~eptr[0];
    end
    i2c_stop();
    check_bank("R4 R5 register contents");
    chk("R5 pointer after write", reg_ptr, eptr);
  endtask

  task automatic do_read(input logic set_cmd, input logic [7:0] cmd, input int n);
    logic a;
    logic [7:0] d;
    i2c_start();
    if (set_cmd) begin
      send_byte(addr_byte(strap, 1'b0), a); chk("R1 address ack", a, 1'b1);
      send_byte(cmd, a);                    chk("R3 command ack", a, 1'b1);
      eptr = cmd[2:0];
      i2c_start();
    end
    send_byte(addr_byte(strap, 1'b1), a); chk("R10 read address ack after START", a, 1'b1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      chk("R6 read data", d, exp_bank[eptr]);
      eptr[0] = ~eptr[0];
    end
    i2c_stop();
    chk("R7 pointer after read", reg_ptr, eptr);
  endtask

  // {command, first byte, second byte}
  localparam logic [23:0] VEC [4] = '{24'h02A53C, 24'h07817E, 24'hFC5AC3, 24'h01FF00};

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    logic [7:0] buf5 [5];
    for (int i = 0; i < 8; i++) exp_bank[i] = 8'(8'h11 * (i + 1));
    eptr  = 3'd0;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R11 reset state
    chk("R11 sda released", sda_oe, 1'b0);
    chk("R11 no write strobe", reg_wr, 1'b0);
    chk("R11 pointer zero", reg_ptr, 3'd0);
    do_read(1'b0, 8'h00, 2);  // R7 R11 read from reset pointer

    foreach (VEC[v]) begin
      buf5[0] = VEC[v][15:8];
      buf5[1] = VEC[v][7:0];
      buf5[2] = 8'h00; buf5[3] = 8'h00; buf5[4] = 8'h00;
      do_write(VEC[v][23:16], 2, buf5);
      do_read(1'b1, VEC[v][23:16], 3);
    end

    // R2 address mismatch
    strap = 3'b101;
    i2c_start();
    send_byte(addr_byte(3'b100, 1'b0), a); chk("R1 mismatch not acked", a, 1'b0);
    send_byte(8'h00, a);                   chk("R2 byte after mismatch not acked", a, 1'b0);
    send_byte(8'h55, a);                   chk("R2 second byte not acked", a, 1'b0);
    i2c_stop();
    chk("R2 pointer unchanged", reg_ptr, eptr);
    check_bank("R2 no register written");

    // R1 new strap value matches
    buf5[0] = 8'h00; buf5[1] = 8'h0F;
    do_write(8'h00, 2, buf5);

    // R8 master NACK releases SDA
    i2c_start();
    send_byte(addr_byte(strap, 1'b1), a); chk("R1 read address ack", a, 1'b1);
    recv_byte(1'b0, d); chk("R8 byte before NACK", d, exp_bank[eptr]);
    eptr[0] = ~eptr[0];
    recv_byte(1'b0, d); chk("R8 SDA released after NACK", d, 8'hFF);
    i2c_stop();
    chk("R8 pointer not advanced after NACK", reg_ptr, eptr);

    // R9 STOP inside a byte
    i2c_start();
    send_byte(addr_byte(strap, 1'b0), a); chk("R1 address ack", a, 1'b1);
    send_byte(8'h06, a);                  chk("R3 command ack", a, 1'b1);
    send_byte(8'h11, a);                  chk("R9 first byte ack", a, 1'b1);
    exp_bank[6] = 8'h11;
    eptr = 3'd7;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    i2c_stop();
    chk("R9 acked byte kept", bank[6], 8'h11);
    chk("R9 partial byte discarded", bank[7], exp_bank[7]);
    chk("R9 pointer after partial byte", reg_ptr, 3'd7);

    // R5 long burst ping-pongs within a pair
    buf5[0] = 8'h01; buf5[1] = 8'h02; buf5[2] = 8'h03; buf5[3] = 8'h04; buf5[4] = 8'h05;
    do_write(8'h04, 5, buf5);
    chk("R5 even register holds last even byte", bank[4], 8'h05);
    chk("R5 odd register holds last odd byte", bank[5], 8'h04);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule